// File: doc/BRIEF.md
# Programmable Trigger Delay and Save Pulse Generator

This block turns an asynchronous external trigger into one save pulse issued after a delay that switches set. The delay is counted in bunch-crossing ticks. A tick is a one-cycle strobe made inside the fast clock domain, one strobe every `TICK_DIV` fast cycles (7 by default, which gives a 132 ns tick from a 53 MHz clock). The trigger passes through a flop synchronizer and a rising-edge detector. A counter then runs on every tick and is compared with a 16-bit reference. The eight switch bits form reference bits 11:4, and every other reference bit is zero.

When the count matches the reference, a delayed trigger is raised. It becomes a save pulse only if the arm input is high. A separate immediate request skips the delay and the arm check. Every save pulse starts on a tick boundary and lasts exactly one tick.

The controller has four states:
- `ST_IDLE`: waiting for an input.
- `ST_COUNT`: counting the delay.
- `ST_PEND`: an immediate request is waiting for the next tick.
- `ST_PULSE`: the save output is high.

Its transitions are:
- IDLE→COUNT on a trigger edge.
- IDLE→PEND on an immediate request, which wins over a trigger edge in the same cycle.
- COUNT→PULSE on a matching tick with arm high.
- COUNT→IDLE on a matching tick with arm low.
- COUNT→PEND on an immediate request, which cancels the delay.
- PEND→PULSE on a tick.
- PULSE→IDLE on a tick.

Top module: `trig_delay_gen`

## Requirements
- R1: While reset is held and after it is released, `save_o` is low until a trigger or an immediate request arrives.
- R2: A trigger that stays high for several ticks starts exactly one delay. Only its rising edge, after `SYNC_STAGES` synchronizer flops, is recognized.
- R3: The reference equals `keys_i` shifted left by 4. `keys_i[0]` is reference bit 4 and `keys_i[7]` is reference bit 11, so each key k adds 16·2^(k−1) ticks. The pulse starts on the (reference+1)-th tick strobe that follows the cycle in which the trigger edge enters the controller. For example, keys `8'hC0` give a reference of 3072.
- R4: With all keys closed (reference 0), the pulse starts on the first tick after the trigger.
- R5: If `arm_i` is low on the matching tick, no pulse is produced. The counter clears and the block returns to idle, ready for the next trigger.
- R6: `save_o` stays high for exactly `TICK_DIV` cycles. It rises in the cycle right after a tick strobe, which is a whole multiple of `TICK_DIV` cycles after reset release.
- R7: An immediate-request edge produces a pulse at the next tick boundary whatever `arm_i` is. It cancels any delay in progress, and no later pulse follows from that delay.
- R8: A new trigger edge that arrives while a delay is running is ignored, and the original fire time is kept.
- R9: Tick strobes are one cycle wide and repeat every `TICK_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_async_i | input | 1 | Asynchronous external trigger, logic level |
| imm_async_i | input | 1 | Asynchronous immediate save request |
| arm_i | input | 1 | Arm enable for the delayed path (quasi-static) |
| keys_i | input | KEY_W | Delay switches, placed at reference bits 11:4 (quasi-static) |
| save_o | output | 1 | Save pulse, one tick long, on a tick boundary |

## Verification
The bench builds the block with `TICK_DIV = 4` and leaves the other parameters at their defaults. This shortens the tick, so even the 3072-tick delay from keys `8'hC0` and the largest random delays fit well within the run. Because 4 does not divide most trigger times, the tick boundary falls at many different phases relative to the trigger edge. That makes the tick alignment and the count off-by-one visible. The default 16-bit counter and 8-bit key field keep the switch-to-reference mapping exactly as used in the field.

// File: rtl/tdg_pkg.sv
package tdg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PEND  = 2'd2,
        ST_PULSE = 2'd3
    } tdg_state_e;

endpackage

// File: rtl/tdg_sync.sv
module tdg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= {sr_q[STAGES-1:0], async_i};
    end

    // the last stage only serves the edge detector
    assign rise_o = sr_q[STAGES-1] & ~sr_q[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);  // R2
endmodule

// File: rtl/tdg_tick.sv
module tdg_tick #(
    parameter int TICK_DIV = 7
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

    logic [TW-1:0] tcnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 tcnt_q <= '0;
        else if (tcnt_q == LAST) tcnt_q <= '0;
        else                     tcnt_q <= tcnt_q + {{(TW-1){1'b0}}, 1'b1};
    end

    assign tick_o = (tcnt_q == LAST);

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);  // R9
endmodule

// File: rtl/tdg_fsm.sv
module tdg_fsm
    import tdg_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int KEY_W   = 8,
    parameter int KEY_LSB = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             trig_rise_i,
    input  logic             imm_rise_i,
    input  logic             arm_i,
    input  logic [KEY_W-1:0] keys_i,
    output logic             save_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    tdg_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] ref_val;

    always_comb begin
        ref_val = '0;
        ref_val[KEY_LSB +: KEY_W] = keys_i;
    end

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (imm_rise_i)       state_d = ST_PEND;
                else if (trig_rise_i) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (imm_rise_i) begin
                    cnt_d   = '0;
                    state_d = ST_PEND;
                end else if (tick_i) begin
                    if (cnt_q == ref_val) begin
                        cnt_d   = '0;
                        state_d = arm_i ? ST_PULSE : ST_IDLE;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
            end
            ST_PEND:  if (tick_i) state_d = ST_PULSE;
            ST_PULSE: if (tick_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        save_o = (state_q == ST_PULSE);
    end

    AST_SAVE_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(save_o) |-> $past(tick_i));  // R6
    AST_SAVE_FALL_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(save_o) |-> $past(tick_i));  // R6
    AST_DISARMED_NO_SAVE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COUNT && tick_i && !imm_rise_i && cnt_q == ref_val && !arm_i)
        |=> !save_o);  // R5
    AST_IDLE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (cnt_q == '0));  // R5
    AST_IMM_REACHES_PULSE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PEND && tick_i) |=> save_o);  // R7
endmodule

// File: rtl/trig_delay_gen.sv
module trig_delay_gen #(
    parameter int TICK_DIV    = 7,
    parameter int CNT_W       = 16,
    parameter int KEY_W       = 8,
    parameter int KEY_LSB     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_async_i,
    input  logic             imm_async_i,
    input  logic             arm_i,
    input  logic [KEY_W-1:0] keys_i,
    output logic             save_o
);
    logic tick;
    logic trig_rise;
    logic imm_rise;

    tdg_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .tick_o(tick)
    );

    tdg_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk(clk), .rst(rst), .async_i(trig_async_i), .rise_o(trig_rise)
    );

    tdg_sync #(.STAGES(SYNC_STAGES)) u_imm_sync (
        .clk(clk), .rst(rst), .async_i(imm_async_i), .rise_o(imm_rise)
    );

    tdg_fsm #(.CNT_W(CNT_W), .KEY_W(KEY_W), .KEY_LSB(KEY_LSB)) u_fsm (
        .clk(clk), .rst(rst), .tick_i(tick),
        .trig_rise_i(trig_rise), .imm_rise_i(imm_rise),
        .arm_i(arm_i), .keys_i(keys_i), .save_o(save_o)
    );
endmodule

// File: tb/sim_trig_delay_gen.sv
module sim_trig_delay_gen;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trig = 1'b0;
    logic       imm = 1'b0;
    logic       arm = 1'b0;
    logic [7:0] keys = 8'h00;
    logic       save;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    trig_delay_gen #(.TICK_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .trig_async_i(trig), .imm_async_i(imm),
        .arm_i(arm), .keys_i(keys), .save_o(save)
    );

    function automatic int next_tick(input int c);
        return ((c + DIV - 1) / DIV) * DIV;
    endfunction

    // cycle index of the first pulse sample for a trigger driven at cycle d
    function automatic int fire_cycle(input int d, input logic [7:0] k);
        return next_tick(d + 4) + (int'(k) * 16) * DIV;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic trial(input logic [7:0] k, input bit armv,
                         input int sec_off, input int imm_off, input string req);
        int d, tf, exp_t, lim, first, highs, c;
        keys = k;
        arm  = armv;
        repeat (3) @(negedge clk);
        d     = cyc;
        tf    = fire_cycle(d, k);
        exp_t = (imm_off >= 0) ? next_tick(d + imm_off + 4) : (armv ? tf : -1);
        lim   = tf + 3 * DIV + 8;
        first = -1;
        highs = 0;
        c     = d;
        trig  = 1'b1;
        imm   = (imm_off == 0);
        while (cyc < lim) begin
            @(negedge clk);
            c = cyc;
            if (save) begin
                highs++;
                if (first < 0) first = c;
            end
            trig = (c < d + DIV + 1) ||
                   (sec_off >= 0 && c >= d + sec_off && c < d + sec_off + DIV + 1);
            imm  = (imm_off >= 0 && c >= d + imm_off && c < d + imm_off + DIV + 1);
        end
        trig = 1'b0;
        imm  = 1'b0;
        check(first == exp_t, {req, " start"}, first, exp_t);
        check(highs == ((exp_t >= 0) ? DIV : 0), {req, " width R6"}, highs,
              (exp_t >= 0) ? DIV : 0);
        if (exp_t >= 0)
            check((first % DIV) == 0, {req, " boundary R6"}, first % DIV, 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        check(save == 1'b0, "R1 reset", int'(save), 0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        check(save == 1'b0, "R1 idle", int'(save), 0);

        trial(8'h00, 1'b1, -1, -1, "R4 zero ref");
        trial(8'h01, 1'b1, -1, -1, "R3 key1");
        trial(8'h80, 1'b1, -1, -1, "R3 key8");
        trial(8'hC0, 1'b1, -1, -1, "R3 keys7+8");
        trial(8'h05, 1'b0, -1, -1, "R5 disarmed");
        trial(8'h02, 1'b1, -1, -1, "R5 ready after disarm");
        trial(8'h03, 1'b1, 2 * DIV + 2, -1, "R8 retrigger");
        trial(8'h04, 1'b1, -1, 5, "R7 cancel");
        trial(8'h02, 1'b0, -1, 1, "R7 disarmed imm");
        trial(8'h01, 1'b1, -1, -1, "R2 single edge");

        for (int i = 0; i < 12; i++) begin
            logic [7:0] k;
            bit         a;
            int         so, io;
            k  = 8'($urandom) & 8'h3F;
            a  = ($urandom % 4) != 0;
            so = -1;
            io = -1;
            if (k != 8'h00) begin
                if ($urandom % 3 == 0) so = 2 * DIV + 2;
                if ($urandom % 4 == 0) io = 1 + int'($urandom % ((int'(k) * 16 * DIV) / 2));
            end
            trial(k, a, so, io, "R3 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule